// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block is a one-byte mailbox between a host and an embedded controller. The host sees two byte ports, a data port and a command port. Each has a write strobe and a read strobe. A host write to either port places the byte in an input holding register and raises the input-full flag. A host read of the data port returns the controller's output byte. A host read of the command port returns a status byte. The controller sees four byte registers on a small register bus: the received byte, the byte to send, the status byte and a control byte.

The control byte sets how the two flags are cleared. In read-clear mode the flags drop on their natural reads. In strobe-clear mode the controller drops them explicitly, by writing one-shot clear bits. The two reset inputs clear the flags in both modes. Two level interrupt outputs tell the controller when a byte has arrived and when the outgoing byte has been taken. The controller reset is asynchronous on assertion and released in step with the clock inside the block.

Top module: `hc_mailbox`

## Requirements
- R1: While `rst_n` is low and after its release, both flags are 0, the control byte reads 0x00, the status byte reads 0x00 and both interrupt outputs are low.
- R2: A host write to either port sets the input-full flag (status bit 1) at the next clock edge and latches the byte, which the controller reads at address 0. Status bit 3 becomes 1 for a command-port write and 0 for a data-port write.
- R3: A controller write to address 1 sets the output-full flag (status bit 0). A host read of the data port returns that byte, and in both modes it clears the output-full flag at the following edge.
- R4: With control bit 5 at 0, a controller read of address 0 clears the input-full flag.
- R5: With control bit 5 at 1, a controller read of address 0 leaves the input-full flag set. A control write with bit 7 at 1 clears it.
- R6: With control bit 5 at 1, a control write with bit 6 at 1 clears the output-full flag. With control bit 5 at 0, bits 6 and 7 of a control write clear nothing.
- R7: A control write with bits 6 and 7 at 0 leaves both flags unchanged. Bits 6 and 7 of the control byte always read back as 0, and the other bits read back as written.
- R8: `host_rst_n` low at a clock edge clears the input-full flag in either mode and leaves the output-full flag unchanged.
- R9: A set event wins over a clear event in the same cycle. A host write together with a clearing controller read leaves input-full set, holding the new byte. A controller write of address 1 together with a host data-port read leaves output-full set.
- R10: `irq_ibf` equals control bit 3 AND input-full. `irq_obe` equals control bit 2 AND NOT output-full. Both are levels.
- R11: The status byte, read on the host command port or at controller address 2, has output-full in bit 0, input-full in bit 1, the last-port bit in bit 3 and 0 elsewhere. Reading it clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Controller reset, active low, asynchronous assert |
| host_rst_n | input | 1 | Host reset, active low, sampled at the clock |
| h_wr | input | 1 | Host write strobe, one cycle per byte |
| h_rd | input | 1 | Host read strobe, one cycle per byte |
| h_cmd | input | 1 | Host port select: 1 command port, 0 data port |
| h_wdata | input | DW | Host write byte |
| h_rdata | output | DW | Host read byte (output byte or status), combinational |
| c_sel | input | 1 | Controller bus access strobe |
| c_we | input | 1 | Controller bus write enable |
| c_addr | input | 2 | Controller register: 0 received, 1 send, 2 status, 3 control |
| c_wdata | input | DW | Controller write byte |
| c_rdata | output | DW | Controller read byte, combinational |
| irq_ibf | output | 1 | Input-full interrupt level |
| irq_obe | output | 1 | Output-empty interrupt level |

## Verification
The assertions assume that each host or controller access lasts one clock cycle. They also assume the host never strobes read and write together, and that the controller never reads and writes in one access. The directed tasks drive one strobe per cycle. The only exceptions are the deliberate pairings of a host access with a controller access that exercise the set-over-clear rule. All inputs change on the falling edge, so every strobe is seen at exactly one rising edge.

// File: rtl/hc_mbox_pkg.sv
package hc_mbox_pkg;
  typedef enum logic [1:0] {
    CA_RXB  = 2'd0,
    CA_TXB  = 2'd1,
    CA_STAT = 2'd2,
    CA_CTRL = 2'd3
  } caddr_e;

  // control byte field positions
  localparam int CB_OBE_IE  = 2;
  localparam int CB_IBF_IE  = 3;
  localparam int CB_STROBE  = 5;
  localparam int CB_OBF_CLR = 6;
  localparam int CB_IBF_CLR = 7;

  // status byte field positions
  localparam int SB_OBF  = 0;
  localparam int SB_IBF  = 1;
  localparam int SB_LAST = 3;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/mbox_host_port.sv
module mbox_host_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          cmd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rxb_o,
  output logic          last_cmd_o
);
  logic [DW-1:0] rxb_q, rxb_d;
  logic          last_q, last_d;

  always_comb begin
    rxb_d  = rxb_q;
    last_d = last_q;
    if (wr_i) begin
      rxb_d  = wdata_i;
      last_d = cmd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxb_q  <= '0;
      last_q <= 1'b0;
    end else begin
      rxb_q  <= rxb_d;
      last_q <= last_d;
    end
  end

  assign rxb_o      = rxb_q;
  assign last_cmd_o = last_q;
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag #(
  parameter bit RD_CLR_BOTH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_mode_i,
  input  logic set_i,
  input  logic rd_clr_i,
  input  logic w1c_i,
  input  logic sync_clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic rd_eff;
  logic clr_any;

  generate
    if (RD_CLR_BOTH) begin : g_rd_always
      assign rd_eff = rd_clr_i;
    end else begin : g_rd_mode0
      assign rd_eff = rd_clr_i & ~strobe_mode_i;
    end
  endgenerate

  assign clr_any = sync_clr_i | rd_eff | (w1c_i & strobe_mode_i);

  always_comb begin
    flag_d = flag_q;
    if (set_i)        flag_d = 1'b1;
    else if (clr_any) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mbox_ctrl_regs.sv
module mbox_ctrl_regs
  import hc_mbox_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl_i,
  input  logic          wr_txb_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] txb_o,
  output logic          ibf_w1c_o,
  output logic          obf_w1c_o
);
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] txb_q, txb_d;

  always_comb begin
    ctrl_d = ctrl_q;
    txb_d  = txb_q;
    if (wr_ctrl_i) begin
      ctrl_d             = wdata_i;
      ctrl_d[CB_OBF_CLR] = 1'b0;
      ctrl_d[CB_IBF_CLR] = 1'b0;
    end
    if (wr_txb_i) txb_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      txb_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      txb_q  <= txb_d;
    end
  end

  assign ibf_w1c_o = wr_ctrl_i & wdata_i[CB_IBF_CLR];
  assign obf_w1c_o = wr_ctrl_i & wdata_i[CB_OBF_CLR];
  assign ctrl_o    = ctrl_q;
  assign txb_o     = txb_q;
endmodule

// File: rtl/hc_mailbox.sv
module hc_mailbox
  import hc_mbox_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_rst_n,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic          h_cmd,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          c_sel,
  input  logic          c_we,
  input  logic [1:0]    c_addr,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] c_rdata,
  output logic          irq_ibf,
  output logic          irq_obe
);
  logic          rst_s_n;
  logic [DW-1:0] rxb, txb, ctrl, status;
  logic          last_cmd;
  logic          ibf, obf;
  logic          ibf_w1c, obf_w1c;
  logic          c_wr_ctrl, c_wr_txb, c_rd_rxb, h_rd_data;
  logic          strobe_mode;

  mbox_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_s_n)
  );

  assign c_wr_ctrl   = c_sel & c_we & (c_addr == CA_CTRL);
  assign c_wr_txb    = c_sel & c_we & (c_addr == CA_TXB);
  assign c_rd_rxb    = c_sel & ~c_we & (c_addr == CA_RXB);
  assign h_rd_data   = h_rd & ~h_cmd;
  assign strobe_mode = ctrl[CB_STROBE];

  mbox_host_port #(.DW(DW)) u_host (
    .clk(clk), .rst_n(rst_s_n), .wr_i(h_wr), .cmd_i(h_cmd),
    .wdata_i(h_wdata), .rxb_o(rxb), .last_cmd_o(last_cmd)
  );

  mbox_ctrl_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_ctrl_i(c_wr_ctrl), .wr_txb_i(c_wr_txb),
    .wdata_i(c_wdata), .ctrl_o(ctrl), .txb_o(txb),
    .ibf_w1c_o(ibf_w1c), .obf_w1c_o(obf_w1c)
  );

  mbox_flag #(.RD_CLR_BOTH(1'b0)) u_ibf (
    .clk(clk), .rst_n(rst_s_n), .strobe_mode_i(strobe_mode),
    .set_i(h_wr), .rd_clr_i(c_rd_rxb), .w1c_i(ibf_w1c),
    .sync_clr_i(~host_rst_n), .flag_o(ibf)
  );

  mbox_flag #(.RD_CLR_BOTH(1'b1)) u_obf (
    .clk(clk), .rst_n(rst_s_n), .strobe_mode_i(strobe_mode),
    .set_i(c_wr_txb), .rd_clr_i(h_rd_data), .w1c_i(obf_w1c),
    .sync_clr_i(1'b0), .flag_o(obf)
  );

  always_comb begin
    status          = '0;
    status[SB_OBF]  = obf;
    status[SB_IBF]  = ibf;
    status[SB_LAST] = last_cmd;
  end

  always_comb begin
    unique case (c_addr)
      CA_RXB:  c_rdata = rxb;
      CA_TXB:  c_rdata = txb;
      CA_STAT: c_rdata = status;
      default: c_rdata = ctrl;
    endcase
  end

  assign h_rdata = h_cmd ? status : txb;
  assign irq_ibf = ctrl[CB_IBF_IE] & ibf;
  assign irq_obe = ctrl[CB_OBE_IE] & ~obf;
endmodule

// File: rtl/hc_mailbox_chk.sv
module hc_mailbox_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic          host_rst_n,
  input logic          h_wr,
  input logic          h_rd,
  input logic          h_cmd,
  input logic          c_sel,
  input logic          c_we,
  input logic [1:0]    c_addr,
  input logic [DW-1:0] c_wdata,
  input logic          ibf,
  input logic          obf,
  input logic          strobe_mode,
  input logic          irq_ibf,
  input logic          irq_obe
);
  logic rd_rxb, wr_txb, wr_ctl, host_take;
  assign rd_rxb    = c_sel && !c_we && c_addr == 2'd0;
  assign wr_txb    = c_sel && c_we && c_addr == 2'd1;
  assign wr_ctl    = c_sel && c_we && c_addr == 2'd3;
  assign host_take = h_rd && !h_cmd;

  AST_IBF_SETS: assert property (@(posedge clk) disable iff (!rst_s_n)
    h_wr |=> ibf); // R2
  AST_OBF_SETS: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_txb |=> obf); // R3
  AST_READ_CLEARS_IBF: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!strobe_mode && ibf && rd_rxb && !h_wr) |=> !ibf); // R4
  AST_STROBE_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (strobe_mode && ibf && rd_rxb && host_rst_n) |=> ibf); // R5
  AST_ZERO_STROBE_KEEPS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_ctl && !c_wdata[6] && obf && !host_take) |=> obf); // R7
  AST_HOST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!host_rst_n && !h_wr) |=> !ibf); // R8
  AST_HOST_RST_KEEPS_OBF: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!host_rst_n && obf && !host_take && !wr_ctl) |=> obf); // R8
  AST_IRQ_IBF_LEVEL: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_ibf |-> ibf); // R10
  AST_IRQ_OBE_LEVEL: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_obe |-> !obf); // R10
endmodule

bind hc_mailbox hc_mailbox_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .host_rst_n(host_rst_n),
  .h_wr(h_wr), .h_rd(h_rd), .h_cmd(h_cmd),
  .c_sel(c_sel), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
  .ibf(ibf), .obf(obf), .strobe_mode(strobe_mode),
  .irq_ibf(irq_ibf), .irq_obe(irq_obe)
);

// File: tb/tb_hc_mailbox.sv
module tb_hc_mailbox;
  logic       clk = 1'b0;
  logic       rst_n, host_rst_n;
  logic       h_wr, h_rd, h_cmd;
  logic [7:0] h_wdata, h_rdata;
  logic       c_sel, c_we;
  logic [1:0] c_addr;
  logic [7:0] c_wdata, c_rdata;
  logic       irq_ibf, irq_obe;
  int         n_chk = 0, n_bad = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  hc_mailbox #(.DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .host_rst_n(host_rst_n),
    .h_wr(h_wr), .h_rd(h_rd), .h_cmd(h_cmd), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .c_sel(c_sel), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .irq_ibf(irq_ibf), .irq_obe(irq_obe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one bus cycle; combinational read data sampled before the rising edge
  task automatic cyc(input logic hw, input logic hr, input logic hc, input logic [7:0] hd,
                     input logic cs, input logic cw, input logic [1:0] ca, input logic [7:0] cd,
                     output logic [7:0] hq, output logic [7:0] cq);
    @(negedge clk);
    h_wr = hw; h_rd = hr; h_cmd = hc; h_wdata = hd;
    c_sel = cs; c_we = cw; c_addr = ca; c_wdata = cd;
    #2;
    hq = h_rdata; cq = c_rdata;
    @(posedge clk); #1;
    h_wr = 0; h_rd = 0; h_cmd = 0; c_sel = 0; c_we = 0;
  endtask

  task automatic hwr(input logic cmd, input logic [7:0] d);
    logic [7:0] a, b;
    cyc(1, 0, cmd, d, 0, 0, 2'd0, 8'h00, a, b);
  endtask
  task automatic hrd(input logic cmd, output logic [7:0] q);
    logic [7:0] b;
    cyc(0, 1, cmd, 8'h00, 0, 0, 2'd0, 8'h00, q, b);
  endtask
  task automatic cwr(input logic [1:0] ad, input logic [7:0] d);
    logic [7:0] a, b;
    cyc(0, 0, 0, 8'h00, 1, 1, ad, d, a, b);
  endtask
  task automatic crd(input logic [1:0] ad, output logic [7:0] q);
    logic [7:0] a;
    cyc(0, 0, 0, 8'h00, 1, 0, ad, 8'h00, a, q);
  endtask

  task automatic t_reset;
    logic [7:0] q;
    check("R1 irq during reset", {6'd0, irq_ibf, irq_obe}, 8'h00);
    crd(2'd2, q); check("R1 status", q, 8'h00);
    crd(2'd3, q); check("R1 control", q, 8'h00);
    check("R1 irqs", {6'd0, irq_ibf, irq_obe}, 8'h00);
  endtask

  task automatic t_host_in;
    logic [7:0] q;
    hwr(0, 8'h5A);
    crd(2'd2, q); check("R2 data-port write status", q, 8'h02);
    crd(2'd0, q); check("R2 latched byte", q, 8'h5A);
    crd(2'd2, q); check("R4 read clears IBF", q, 8'h00);
    hwr(1, 8'h80);
    hrd(1, q); check("R11 host status after command write", q, 8'h0A);
    hrd(1, q); check("R11 status read clears nothing", q, 8'h0A);
    crd(2'd0, q); check("R2 command byte", q, 8'h80);
    crd(2'd2, q); check("R4 IBF cleared, last bit kept", q, 8'h08);
  endtask

  task automatic t_host_out;
    logic [7:0] q;
    cwr(2'd1, 8'h33);
    hrd(1, q); check("R3 OBF set", q & 8'h01, 8'h01);
    hrd(0, q); check("R3 host gets byte", q, 8'h33);
    crd(2'd2, q); check("R3 OBF cleared by host read", q & 8'h01, 8'h00);
  endtask

  task automatic t_strobe_mode;
    logic [7:0] q;
    cwr(2'd3, 8'h20);
    hwr(0, 8'h11);
    crd(2'd0, q); check("R5 byte in strobe mode", q, 8'h11);
    crd(2'd2, q); check("R5 read keeps IBF", q & 8'h02, 8'h02);
    cwr(2'd3, 8'h20);
    crd(2'd2, q); check("R7 zero strobe keeps IBF", q & 8'h02, 8'h02);
    cwr(2'd3, 8'hA0);
    crd(2'd3, q); check("R7 strobe bits read 0", q, 8'h20);
    crd(2'd2, q); check("R5 bit7 clears IBF", q & 8'h02, 8'h00);
    cwr(2'd1, 8'h44);
    cwr(2'd3, 8'h60);
    crd(2'd2, q); check("R6 bit6 clears OBF", q & 8'h01, 8'h00);
    cwr(2'd1, 8'h45);
    cwr(2'd3, 8'h3F);
    crd(2'd3, q); check("R7 other bits read back", q, 8'h3F);
    crd(2'd2, q); check("R7 zero strobe keeps OBF", q & 8'h01, 8'h01);
    hrd(0, q); check("R3 host byte in strobe mode", q, 8'h45);
    crd(2'd2, q); check("R3 host read clears OBF in strobe mode", q & 8'h01, 8'h00);
    cwr(2'd3, 8'h00);
  endtask

  task automatic t_read_mode_strobes;
    logic [7:0] q;
    hwr(0, 8'h22);
    cwr(2'd1, 8'h23);
    cwr(2'd3, 8'hC0);
    crd(2'd2, q); check("R6 strobes ignored in read-clear mode", q & 8'h03, 8'h03);
    crd(2'd0, q);
    hrd(0, q);
    cwr(2'd3, 8'h00);
  endtask

  task automatic t_host_reset;
    logic [7:0] q;
    cwr(2'd3, 8'h20);
    hwr(0, 8'h99);
    cwr(2'd1, 8'h98);
    @(negedge clk); host_rst_n = 0;
    @(negedge clk); host_rst_n = 1;
    crd(2'd2, q); check("R8 host reset clears IBF only", q & 8'h03, 8'h01);
    hrd(0, q);
    cwr(2'd3, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] a, q;
    hwr(0, 8'h01);
    cyc(1, 0, 0, 8'h77, 1, 0, 2'd0, 8'h00, a, q);
    check("R9 clearing read saw old byte", q, 8'h01);
    crd(2'd2, q); check("R9 IBF kept by new write", q & 8'h02, 8'h02);
    crd(2'd0, q); check("R9 new byte held", q, 8'h77);
    cwr(2'd1, 8'h87);
    cyc(0, 1, 0, 8'h00, 1, 1, 2'd1, 8'h88, a, q);
    check("R9 host read saw old byte", a, 8'h87);
    crd(2'd2, q); check("R9 OBF kept by new write", q & 8'h01, 8'h01);
    hrd(0, q); check("R9 new out byte", q, 8'h88);
  endtask

  task automatic t_irq;
    logic [7:0] q;
    cwr(2'd3, 8'h0C);
    check("R10 empty both", {6'd0, irq_ibf, irq_obe}, 8'h01);
    hwr(0, 8'h10);
    check("R10 input full irq", {6'd0, irq_ibf, irq_obe}, 8'h03);
    cwr(2'd1, 8'h20);
    check("R10 output full drops obe", {6'd0, irq_ibf, irq_obe}, 8'h02);
    cwr(2'd3, 8'h00);
    check("R10 disabled", {6'd0, irq_ibf, irq_obe}, 8'h00);
    crd(2'd0, q);
    hrd(0, q);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; host_rst_n = 1;
    h_wr = 0; h_rd = 0; h_cmd = 0; h_wdata = 0;
    c_sel = 0; c_we = 0; c_addr = 0; c_wdata = 0;
    repeat (3) @(posedge clk); #1;
    t_reset;
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk); #1;
    t_reset;
    t_host_in;
    t_host_out;
    t_strobe_mode;
    t_read_mode_strobes;
    t_host_reset;
    t_set_wins;
    t_irq;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule